// File: doc/BRIEF.md
# Enhanced parallel port host cycle bridge

This block connects a synchronous ISA-style host register port to a peripheral on an Enhanced Parallel Port (EPP 1.7 style) link. A host read or write to one of two decoded offsets becomes one peripheral transfer. A read or write at offset 3 produces an address transfer. A read or write at offset 4 produces a data transfer. The bridge first sets the bus direction, the write qualifier and the output data. Only after that does it drop the matching strobe. It then waits for the peripheral's acknowledge, which is the hold line rising. Until the acknowledge arrives, it keeps the host's ready line low so that the host cycle is stretched. A stalled transfer is ended by a time-out counter. The time-out also sets a sticky status flag that the host clears by writing 1 to it.

The host side is a plain strobed register port, not a stream, so it has no valid/ready pair. Back-pressure appears only as `host_ready` held low. The host must keep its strobe, offset and write byte steady until it sees `host_ready` high, and it ends the transfer by releasing its strobe. The host interrupt is a straight copy of the peripheral interrupt. The peripheral reset output follows a control input. Two legacy control bits can take over the write qualifier, and a third control bit parks the bus direction as input.

Top module: `epp_host_bridge`

## Requirements
- R1: With `host_cs` high and `host_rd_n` or `host_wr_n` low, offset 3 runs a transfer on `per_astrobe_n` and offset 4 runs one on `per_dstrobe_n`. Every other offset starts no transfer: both strobes stay high and `host_ready` stays high. The two strobes are never low together.
- R2: A read transfer spends one setup cycle with `per_dir_in`=1, `per_wr_n`=1, `per_dout_en`=0 and both strobes high. The selected strobe goes low in the following cycle.
- R3: A write transfer spends one setup cycle with `per_wr_n`=0, `per_dout_en`=1, `per_dir_in`=0 and `per_dout` equal to the host byte. The selected strobe then goes low. `per_dout` holds that byte until the strobe rises.
- R4: `host_ready` goes low in the first clock after the transfer starts. It stays low until a clock edge samples `per_hold_n`=1 with the strobe low, or until the time-out fires. It reads high from the cycle after that edge.
- R5: Once the transfer is acknowledged, the strobe stays low for as long as the host strobe stays low. The strobe rises in the cycle after the host releases. In that same cycle `per_dout_en` returns to 0, `per_wr_n` returns to 1 and `per_dir_in` returns to its rest value.
- R6: On a read transfer, the byte on `per_din` at the acknowledging edge is captured. A host read of offset 3 or 4 returns it on `host_dout`. A write transfer leaves the captured byte unchanged.
- R7: If the strobe stays low for TMO_CYCLES clock edges with `per_hold_n`=0, the transfer ends as if acknowledged. Bit 0 of offset 1 becomes 1, and a read transfer captures 8'hFF. If `per_hold_n` is high on that last edge, the transfer completes normally and no time-out is recorded.
- R8: Writing a byte with bit 0 set to offset 1 clears the time-out flag. Writing bit 0 as 0 leaves the flag unchanged. Offset 1 reads back {7'b0, flag}. Other offsets read 8'h00.
- R9: Outside a transfer, `per_dir_in` equals `ctl_dir_in`. During a read it is 1, and during a write it is 0.
- R10: While `ctl_wr_force` is 1, `per_wr_n` equals `ctl_wr_val` at all times. No other output changes because of it.
- R11: `host_irq` equals `per_irq` without inversion. `per_reset_n` is the inverse of `ctl_per_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_cs | input | 1 | block selected by the host address decode |
| host_addr | input | 3 | register offset within the block |
| host_rd_n | input | 1 | host read strobe, active low |
| host_wr_n | input | 1 | host write strobe, active low |
| host_din | input | 8 | host write byte |
| host_dout | output | 8 | host read byte |
| host_ready | output | 1 | host cycle ready, low stretches the cycle |
| host_irq | output | 1 | interrupt to the host |
| ctl_dir_in | input | 1 | parks the bus direction as input when idle |
| ctl_wr_force | input | 1 | legacy control takes over the write qualifier |
| ctl_wr_val | input | 1 | value driven on the write qualifier when forced |
| ctl_per_reset | input | 1 | request to reset the peripheral |
| per_dout | output | 8 | byte driven toward the peripheral |
| per_dout_en | output | 1 | output enable for the peripheral data bus |
| per_din | input | 8 | byte received from the peripheral data bus |
| per_wr_n | output | 1 | write qualifier, low on write transfers |
| per_dstrobe_n | output | 1 | data strobe, active low |
| per_astrobe_n | output | 1 | address strobe, active low |
| per_hold_n | input | 1 | peripheral hold; low stalls, rising acknowledges |
| per_irq | input | 1 | peripheral interrupt, active high |
| per_reset_n | output | 1 | peripheral reset, active low |
| per_dir_in | output | 1 | bus direction, 1 means input |

## Verification
The bench models the peripheral with a chosen acknowledge delay. It sweeps delays from zero up to one cycle below the time-out limit. A bridge with an off-by-one in the limit would then either flag a time-out or complete the transfer a cycle early. The bench also holds the host strobe for several cycles after ready, to catch a bridge that drops the peripheral strobe on the acknowledge instead of on the host release. It checks the setup cycle for a strobe that falls before the direction and data are settled. Further directed cases cover the status clear with bit 0 set and with bit 0 clear, the write qualifier override during a live read, direction parking after a read with the direction bit set, and offsets that must start nothing.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_DONE
  } cyc_state_e;

  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_STATUS = 3'd1;
  localparam logic [OFS_W-1:0] OFS_ADDR   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_DATA   = 3'd4;
  localparam logic [7:0]       TMO_BYTE   = 8'hFF;
endpackage

// File: rtl/epp_stall_timer.sv
module epp_stall_timer #(
  parameter int CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cs,
  input  logic [OFS_W-1:0] host_addr,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             per_hold_n,
  input  logic             expired,
  output cyc_state_e       state,
  output logic             start,
  output logic             is_read,
  output logic             is_addr,
  output logic             ack_seen,
  output logic             tmo_hit
);
  cyc_state_e nxt;
  logic       decoded;

  assign decoded  = (host_addr == OFS_ADDR) || (host_addr == OFS_DATA);
  assign start    = (state == ST_IDLE) && host_cs && decoded && (!host_rd_n || !host_wr_n);
  assign ack_seen = (state == ST_STROBE) && per_hold_n;
  assign tmo_hit  = (state == ST_STROBE) && !per_hold_n && expired;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_SETUP;
      ST_SETUP:  nxt = ST_STROBE;
      ST_STROBE: if (ack_seen || tmo_hit) nxt = ST_DONE;
      ST_DONE:   if (host_rd_n && host_wr_n) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      is_read <= 1'b0;
      is_addr <= 1'b0;
    end else begin
      state <= nxt;
      if (start) begin
        is_read <= !host_rd_n;
        is_addr <= (host_addr == OFS_ADDR);
      end
    end
  end
endmodule

// File: rtl/epp_bridge_regs.sv
module epp_bridge_regs
  import epp_bridge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic             ack_seen,
  input  logic             tmo_hit,
  input  logic             host_cs,
  input  logic [OFS_W-1:0] host_addr,
  input  logic             host_wr_n,
  input  logic [DW-1:0]    host_din,
  input  logic [DW-1:0]    per_din,
  output logic [DW-1:0]    wbyte,
  output logic [DW-1:0]    host_dout,
  output logic             tmo_flag
);
  logic [DW-1:0] rbyte;
  logic          clr;

  assign clr = host_cs && !host_wr_n && (host_addr == OFS_STATUS) && host_din[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte    <= '0;
      rbyte    <= '0;
      tmo_flag <= 1'b0;
    end else begin
      if (start) wbyte <= host_din;
      if (is_read && ack_seen)     rbyte <= per_din;
      else if (is_read && tmo_hit) rbyte <= DW'(TMO_BYTE);
      if (tmo_hit)  tmo_flag <= 1'b1;
      else if (clr) tmo_flag <= 1'b0;
    end
  end

  always_comb begin
    if (host_addr == OFS_ADDR || host_addr == OFS_DATA) host_dout = rbyte;
    else if (host_addr == OFS_STATUS) host_dout = {{(DW-1){1'b0}}, tmo_flag};
    else host_dout = '0;
  end
endmodule

// File: rtl/epp_host_bridge.sv
module epp_host_bridge
  import epp_bridge_pkg::*;
#(
  parameter int TMO_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs,
  input  logic [2:0] host_addr,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  output logic       host_ready,
  output logic       host_irq,
  input  logic       ctl_dir_in,
  input  logic       ctl_wr_force,
  input  logic       ctl_wr_val,
  input  logic       ctl_per_reset,
  output logic [7:0] per_dout,
  output logic       per_dout_en,
  input  logic [7:0] per_din,
  output logic       per_wr_n,
  output logic       per_dstrobe_n,
  output logic       per_astrobe_n,
  input  logic       per_hold_n,
  input  logic       per_irq,
  output logic       per_reset_n,
  output logic       per_dir_in
);
  cyc_state_e state;
  logic start, is_read, is_addr, ack_seen, tmo_hit, expired, tmo_flag;
  logic in_cyc, rd_cyc, wr_cyc, stb_on;

  epp_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .per_hold_n(per_hold_n),
    .expired(expired), .state(state), .start(start), .is_read(is_read),
    .is_addr(is_addr), .ack_seen(ack_seen), .tmo_hit(tmo_hit)
  );

  epp_stall_timer #(.CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_STROBE), .expired(expired)
  );

  epp_bridge_regs #(.DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
    .ack_seen(ack_seen), .tmo_hit(tmo_hit), .host_cs(host_cs),
    .host_addr(host_addr), .host_wr_n(host_wr_n), .host_din(host_din),
    .per_din(per_din), .wbyte(per_dout), .host_dout(host_dout),
    .tmo_flag(tmo_flag)
  );

  assign in_cyc = (state != ST_IDLE);
  assign rd_cyc = in_cyc && is_read;
  assign wr_cyc = in_cyc && !is_read;
  assign stb_on = (state == ST_STROBE) || (state == ST_DONE);

  assign per_dstrobe_n = !(stb_on && !is_addr);
  assign per_astrobe_n = !(stb_on && is_addr);
  assign per_dir_in    = rd_cyc || (!wr_cyc && ctl_dir_in);
  assign per_wr_n      = ctl_wr_force ? ctl_wr_val : !wr_cyc;
  assign per_dout_en   = wr_cyc;
  assign host_ready    = !((state == ST_SETUP) || (state == ST_STROBE));
  assign host_irq      = per_irq;
  assign per_reset_n   = !ctl_per_reset;
endmodule

// File: rtl/epp_bridge_chk.sv
module epp_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_rd_n,
  input logic       host_wr_n,
  input logic       host_ready,
  input logic       host_irq,
  input logic       ctl_dir_in,
  input logic [7:0] per_dout,
  input logic       per_dout_en,
  input logic       per_dstrobe_n,
  input logic       per_astrobe_n,
  input logic       per_hold_n,
  input logic       per_irq,
  input logic       per_dir_in,
  input logic       tmo_flag
);
  logic stb_low;
  assign stb_low = !per_dstrobe_n || !per_astrobe_n;

  p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_dstrobe_n && !per_astrobe_n));

  p_read_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low && !per_dout_en) |-> per_dir_in);

  p_write_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_dout_en |-> !per_dir_in);

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_dout_en && $past(per_dout_en) && $past(rst_n)) |-> $stable(per_dout));

  p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_ready) && $past(rst_n)) |-> stb_low);

  p_release_after_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb_low) && !stb_low && $past(rst_n)) |-> $past(host_rd_n && host_wr_n));

  p_flag_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmo_flag) && $past(rst_n)) |-> ($past(!host_ready) && $past(!per_hold_n)));

  p_idle_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !stb_low && !per_dout_en) |-> (per_dir_in == ctl_dir_in));

  p_irq_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == per_irq);
endmodule

bind epp_host_bridge epp_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
  .host_ready(host_ready), .host_irq(host_irq), .ctl_dir_in(ctl_dir_in),
  .per_dout(per_dout), .per_dout_en(per_dout_en),
  .per_dstrobe_n(per_dstrobe_n), .per_astrobe_n(per_astrobe_n),
  .per_hold_n(per_hold_n), .per_irq(per_irq), .per_dir_in(per_dir_in),
  .tmo_flag(tmo_flag)
);

// File: tb/sim_epp_host_bridge.sv
module sim_epp_host_bridge;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_din = 8'd0;
  logic [7:0] host_dout;
  logic host_ready, host_irq;
  logic ctl_dir_in = 1'b0, ctl_wr_force = 1'b0, ctl_wr_val = 1'b1, ctl_per_reset = 1'b0;
  logic [7:0] per_dout;
  logic per_dout_en;
  logic [7:0] per_din = 8'h00;
  logic per_wr_n, per_dstrobe_n, per_astrobe_n;
  logic per_hold_n = 1'b0;
  logic per_irq = 1'b0;
  logic per_reset_n, per_dir_in;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_flag = 1'b0;
  logic [7:0] exp_rbyte = 8'h00;

  always #2 clk = ~clk;

  epp_host_bridge #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_din(host_din),
    .host_dout(host_dout), .host_ready(host_ready), .host_irq(host_irq),
    .ctl_dir_in(ctl_dir_in), .ctl_wr_force(ctl_wr_force), .ctl_wr_val(ctl_wr_val),
    .ctl_per_reset(ctl_per_reset), .per_dout(per_dout), .per_dout_en(per_dout_en),
    .per_din(per_din), .per_wr_n(per_wr_n), .per_dstrobe_n(per_dstrobe_n),
    .per_astrobe_n(per_astrobe_n), .per_hold_n(per_hold_n), .per_irq(per_irq),
    .per_reset_n(per_reset_n), .per_dir_in(per_dir_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_wr_n(input bit writing);
    return ctl_wr_force ? ctl_wr_val : !writing;
  endfunction

  function automatic logic [7:0] exp_capture(input bit timed_out, input logic [7:0] b);
    return timed_out ? 8'hFF : b;
  endfunction

  // One peripheral transfer. d = acknowledge delay in cycles after the strobe
  // falls; d >= TMO means the peripheral never acknowledges.
  task automatic epp_xfer(input bit rd, input bit adr, input logic [7:0] wb,
                          input int d, input int hold);
    logic [7:0] rb;
    bit tmo;
    int done_k;
    rb = 8'($urandom);
    tmo = (d > TMO - 1);
    done_k = tmo ? TMO + 2 : 3 + d;
    host_cs = 1'b1; host_addr = adr ? 3'd3 : 3'd4;
    host_rd_n = !rd; host_wr_n = rd; host_din = wb;
    @(negedge clk); // setup cycle
    chk(per_dstrobe_n && per_astrobe_n, rd ? "R2 strobes high in setup" : "R3 strobes high in setup",
        {per_dstrobe_n, per_astrobe_n}, 2'b11);
    chk(per_dir_in == rd, rd ? "R2 dir in setup" : "R3 dir in setup", per_dir_in, rd);
    chk(per_wr_n == exp_wr_n(!rd), rd ? "R2 wr_n in setup" : "R3 wr_n in setup", per_wr_n, exp_wr_n(!rd));
    chk(per_dout_en == !rd, rd ? "R2 bus released" : "R3 bus driven", per_dout_en, !rd);
    if (!rd) chk(per_dout == wb, "R3 data in setup", per_dout, wb);
    chk(host_ready == 1'b0, "R4 ready low in setup", host_ready, 0);
    @(negedge clk); // strobe cycle
    if (adr) chk(!per_astrobe_n && per_dstrobe_n, "R1 address strobe", {per_astrobe_n, per_dstrobe_n}, 2'b01);
    else     chk(!per_dstrobe_n && per_astrobe_n, "R1 data strobe", {per_dstrobe_n, per_astrobe_n}, 2'b01);
    if (!tmo && d == 0) begin per_hold_n = 1'b1; per_din = rb; end
    for (int k = 3; k <= done_k; k++) begin
      @(negedge clk);
      if (k < done_k) begin
        chk(host_ready == 1'b0, "R4 ready stretched", host_ready, 0);
        if (!tmo && k == 2 + d) begin per_hold_n = 1'b1; per_din = rb; end
      end else begin
        chk(host_ready == 1'b1, tmo ? "R7 ready after time-out" : "R4 ready after ack", host_ready, 1);
        chk(!(per_dstrobe_n && per_astrobe_n), "R5 strobe held", {per_dstrobe_n, per_astrobe_n}, 2'b01);
        if (!rd) chk(per_dout_en && per_dout == wb, "R3 data held", per_dout, wb);
      end
    end
    if (tmo) exp_flag = 1'b1;
    if (rd) begin
      exp_rbyte = exp_capture(tmo, rb);
      chk(host_dout == exp_rbyte, tmo ? "R7 read of stalled transfer" : "R6 read data", host_dout, exp_rbyte);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(!(per_dstrobe_n && per_astrobe_n), "R5 strobe kept while host holds",
          {per_dstrobe_n, per_astrobe_n}, 2'b01);
    end
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    @(negedge clk);
    chk(per_dstrobe_n && per_astrobe_n, "R5 strobe released", {per_dstrobe_n, per_astrobe_n}, 2'b11);
    chk(!per_dout_en, "R5 bus released", per_dout_en, 0);
    chk(per_wr_n == exp_wr_n(1'b0), "R5 wr_n rest", per_wr_n, exp_wr_n(1'b0));
    chk(per_dir_in == ctl_dir_in, "R9 dir rest", per_dir_in, ctl_dir_in);
    host_cs = 1'b0; per_hold_n = 1'b0; per_din = 8'($urandom);
    @(negedge clk);
  endtask

  task automatic read_status(input string req);
    host_cs = 1'b1; host_addr = 3'd1; host_rd_n = 1'b0;
    @(negedge clk);
    chk(host_dout == {7'b0, exp_flag}, req, host_dout, {7'b0, exp_flag});
    chk(host_ready && per_dstrobe_n && per_astrobe_n, "R1 status offset starts nothing",
        {host_ready, per_dstrobe_n, per_astrobe_n}, 3'b111);
    host_rd_n = 1'b1; host_cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_status(input logic [7:0] v);
    host_cs = 1'b1; host_addr = 3'd1; host_wr_n = 1'b0; host_din = v;
    @(negedge clk);
    host_wr_n = 1'b1; host_cs = 1'b0;
    if (v[0]) exp_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(per_dstrobe_n && per_astrobe_n && host_ready, "R4 reset idle", {per_dstrobe_n, per_astrobe_n, host_ready}, 3'b111);
    chk(per_dir_in == 1'b0 && per_wr_n == 1'b1 && !per_dout_en, "R9 reset outputs",
        {per_dir_in, per_wr_n, per_dout_en}, 3'b010);
    read_status("R8 flag clear after reset");

    // undecoded offsets start nothing
    for (int a = 0; a < 8; a++) begin
      if (a == 3 || a == 4) continue;
      host_cs = 1'b1; host_addr = 3'(a); host_rd_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(per_dstrobe_n && per_astrobe_n && host_ready, "R1 undecoded offset",
          {per_dstrobe_n, per_astrobe_n, host_ready}, 3'b111);
      host_rd_n = 1'b1; host_cs = 1'b0;
      @(negedge clk);
    end

    // directed transfers
    epp_xfer(1'b1, 1'b0, 8'h00, 0, 0);
    epp_xfer(1'b0, 1'b1, 8'hA5, 3, 2);
    epp_xfer(1'b1, 1'b1, 8'h00, TMO - 1, 1);
    read_status("R7 limit-1 ack is no time-out");
    epp_xfer(1'b0, 1'b0, 8'h3C, 5, 0);
    chk(host_dout == exp_rbyte, "R6 write keeps read byte", host_dout, exp_rbyte);
    host_addr = 3'd4;
    @(negedge clk);
    chk(host_dout == exp_rbyte, "R6 write keeps read byte", host_dout, exp_rbyte);

    // time-out and sticky flag
    epp_xfer(1'b1, 1'b0, 8'h00, TMO + 10, 0);
    read_status("R7 flag set by time-out");
    write_status(8'hFE);
    read_status("R8 zero write keeps flag");
    write_status(8'h01);
    read_status("R8 one write clears flag");

    // direction bit parked as input
    ctl_dir_in = 1'b1;
    @(negedge clk);
    chk(per_dir_in == 1'b1, "R9 idle dir follows control", per_dir_in, 1);
    epp_xfer(1'b1, 1'b0, 8'h00, 2, 0);
    chk(per_dir_in == 1'b1, "R9 dir stays input after read", per_dir_in, 1);
    epp_xfer(1'b0, 1'b0, 8'h77, 1, 0);
    ctl_dir_in = 1'b0;
    @(negedge clk);
    chk(per_dir_in == 1'b0, "R9 idle dir low", per_dir_in, 0);

    // write qualifier override
    ctl_wr_force = 1'b1; ctl_wr_val = 1'b0;
    @(negedge clk);
    chk(per_wr_n == 1'b0, "R10 override idle", per_wr_n, 0);
    epp_xfer(1'b1, 1'b1, 8'h00, 2, 0);
    ctl_wr_val = 1'b1;
    epp_xfer(1'b0, 1'b0, 8'h5A, 2, 0);
    ctl_wr_force = 1'b0;
    @(negedge clk);
    chk(per_wr_n == 1'b1, "R10 override removed", per_wr_n, 1);

    // interrupt and reset pass-through
    per_irq = 1'b1; ctl_per_reset = 1'b1;
    @(negedge clk);
    chk(host_irq == 1'b1 && per_reset_n == 1'b0, "R11 irq and reset", {host_irq, per_reset_n}, 2'b10);
    per_irq = 1'b0; ctl_per_reset = 1'b0;
    @(negedge clk);
    chk(host_irq == 1'b0 && per_reset_n == 1'b1, "R11 irq and reset", {host_irq, per_reset_n}, 2'b01);

    // constrained random transfers
    for (int n = 0; n < 60; n++) begin
      ctl_dir_in = ($urandom % 4 == 0);
      epp_xfer(1'($urandom), 1'($urandom), 8'($urandom), int'($urandom % (TMO + 4)), int'($urandom % 3));
      if ($urandom % 5 == 0) begin
        read_status("R7 random flag");
        write_status(8'($urandom));
        read_status("R8 random clear");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule